// File: doc/BRIEF.md
# FM Operator Phase Increment Generator

This block turns the pitch settings of one FM synthesis operator into the per-sample phase increment that a phase accumulator adds every sample. It takes the channel frequency number and octave value, optionally applies a vibrato (low-frequency phase modulation) correction, shifts the result into the selected octave and finally applies a small detune offset. The detune offset depends on the key code and on a detune setting.

A host pulses `start` with all settings valid. One clock later the registered increment appears on `incr`, and `done` is high for exactly that cycle. The vibrato offset table lives outside the block. The block presents a lookup index on `pmIndex`, built combinationally from the current inputs, and the external table answers on `lfoOffset` within the same cycle. The detune amounts come from a small table that the block computes internally. Phase accumulation and frequency multiples are handled elsewhere.

Top module: `fm_phase_inc`

## Requirements
- R1: While `rstN` is low, and after reset until the first start, `incr` is 0 and `done` is 0.
- R2: When `pms` is 0, the base increment equals `fnum` zero-extended. In this case `lfoOffset` has no effect and `fnum` is not doubled.
- R3: When `pms` is nonzero, the base increment is (2*`fnum` + `lfoOffset`) modulo 4096. Here `lfoOffset` is an 8-bit two's-complement value.
- R4: `pmIndex` is combinational and equals {`fnum`[10:4], `pms`[2:0], `lfoStep`[4:0]}. The `fnum` bits occupy bits 14:8, `pms` bits 7:5 and `lfoStep` bits 4:0.
- R5: When `block` is 0, the octave increment is the base shifted right by one. When `block` is b>0, the octave increment is the base shifted left by b-1. The result is kept modulo 2^17.
- R6: The detune amount uses sel = `detune`[1:0]. It is 0 when sel is 0, and floor(sel*(`keyCode`+1)/4) otherwise.
- R7: When `detune`[2] is 0, the detune amount is added to the octave increment. When it is 1, the amount is subtracted. The final value wraps modulo 2^17.
- R8: `incr` takes the value computed from the inputs present at a rising edge where `start` is 1, and `done` is 1 for the following cycle only. Without `start`, `incr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture strobe for a new increment |
| fnum | input | 11 | Channel frequency number |
| block | input | 3 | Octave value |
| pms | input | 3 | Phase-modulation sensitivity, 0 disables vibrato |
| lfoStep | input | 5 | Current vibrato step |
| lfoOffset | input | 8 | Signed vibrato offset returned by the external table |
| keyCode | input | 5 | Key code used for the detune lookup |
| detune | input | 3 | Detune setting: bits 1:0 magnitude select, bit 2 direction |
| pmIndex | output | 15 | Lookup index for the external vibrato table |
| incr | output | 17 | Registered phase increment |
| done | output | 1 | One-cycle pulse marking a fresh `incr` |

## Verification
The bench builds the block with its default widths: an 11-bit frequency number, 3-bit octave, 8-bit signed vibrato offset and 17-bit increment. These widths make every wrap point reachable. A small frequency number combined with a negative offset drives the 12-bit vibrato sum below zero. Octave 7 with a large base pushes past 17 bits. A zero base with a subtracting detune wraps downward. The external vibrato table is modelled in the bench as a computed function of the index, so an index fault shows up both as a direct mismatch and as a wrong increment.

// File: rtl/fm_phase_inc_pkg.sv
package fm_phase_inc_pkg;
  typedef struct packed {
    logic capture;
    logic finish;
  } incStrobes_t;
endpackage

// File: rtl/fm_phase_inc_detune_rom.sv
module fm_phase_inc_detune_rom #(
  parameter int KC_W = 5,
  parameter int DT_W = KC_W + 1
) (
  input  logic [KC_W-1:0] keyCode,
  input  logic [1:0]      sel,
  output logic [DT_W-1:0] amount
);
  localparam int ProdW = KC_W + 3;

  logic [ProdW-1:0] prod;

  always_comb begin
    prod = (ProdW'(keyCode) + ProdW'(1)) * ProdW'(sel);
    if (sel == 2'd0) amount = '0;
    else             amount = DT_W'(prod >> 2);
  end
endmodule

// File: rtl/fm_phase_inc_ctrl.sv
module fm_phase_inc_ctrl
  import fm_phase_inc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output incStrobes_t strobes,
  output logic        done
);
  always_comb begin
    strobes.capture = start;
    strobes.finish  = start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= strobes.finish;
  end
endmodule

// File: rtl/fm_phase_inc_datapath.sv
module fm_phase_inc_datapath
  import fm_phase_inc_pkg::*;
#(
  parameter int FNUM_W  = 11,
  parameter int BLOCK_W = 3,
  parameter int PMS_W   = 3,
  parameter int LFO_W   = 8,
  parameter int KC_W    = 5,
  parameter int INC_W   = 17,
  parameter int DT_W    = KC_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  incStrobes_t        strobes,
  input  logic [FNUM_W-1:0]  fnum,
  input  logic [BLOCK_W-1:0] block,
  input  logic [PMS_W-1:0]   pms,
  input  logic [LFO_W-1:0]   lfoOffset,
  input  logic [KC_W-1:0]    keyCode,
  input  logic [2:0]         detune,
  output logic [INC_W-1:0]   incr
);
  localparam int BaseW = FNUM_W + 1;

  logic [BaseW-1:0] offExt;
  logic [BaseW-1:0] baseInc;
  logic [INC_W-1:0] wideBase;
  logic [INC_W-1:0] octInc;
  logic [DT_W-1:0]  dtAmount;
  logic [INC_W-1:0] nextInc;
  logic [INC_W-1:0] incQ;

  // vibrato correction, wrapped to BaseW bits
  always_comb begin
    offExt = {{(BaseW - LFO_W){lfoOffset[LFO_W-1]}}, lfoOffset};
    if (pms != '0) baseInc = {fnum, 1'b0} + offExt;
    else           baseInc = BaseW'(fnum);
  end

  // octave placement
  always_comb begin
    wideBase = INC_W'(baseInc);
    if (block == '0) octInc = wideBase >> 1;
    else             octInc = wideBase << (block - BLOCK_W'(1));
  end

  fm_phase_inc_detune_rom #(
    .KC_W(KC_W),
    .DT_W(DT_W)
  ) dtRom_i (
    .keyCode(keyCode),
    .sel    (detune[1:0]),
    .amount (dtAmount)
  );

  always_comb begin
    if (detune[2]) nextInc = octInc - INC_W'(dtAmount);
    else           nextInc = octInc + INC_W'(dtAmount);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                incQ <= '0;
    else if (strobes.capture) incQ <= nextInc;
  end

  assign incr = incQ;
endmodule

// File: rtl/fm_phase_inc.sv
module fm_phase_inc
  import fm_phase_inc_pkg::*;
#(
  parameter int FNUM_W  = 11,
  parameter int BLOCK_W = 3,
  parameter int PMS_W   = 3,
  parameter int STEP_W  = 5,
  parameter int LFO_W   = 8,
  parameter int KC_W    = 5,
  parameter int INC_W   = 17,
  localparam int IDX_W  = (FNUM_W - 4) + PMS_W + STEP_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [FNUM_W-1:0]  fnum,
  input  logic [BLOCK_W-1:0] block,
  input  logic [PMS_W-1:0]   pms,
  input  logic [STEP_W-1:0]  lfoStep,
  input  logic [LFO_W-1:0]   lfoOffset,
  input  logic [KC_W-1:0]    keyCode,
  input  logic [2:0]         detune,
  output logic [IDX_W-1:0]   pmIndex,
  output logic [INC_W-1:0]   incr,
  output logic               done
);
  localparam int DtW = KC_W + 1;

  incStrobes_t strobes;

  // index for the external vibrato table
  assign pmIndex = {fnum[FNUM_W-1:4], pms, lfoStep};

  fm_phase_inc_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobes(strobes),
    .done   (done)
  );

  fm_phase_inc_datapath #(
    .FNUM_W (FNUM_W),
    .BLOCK_W(BLOCK_W),
    .PMS_W  (PMS_W),
    .LFO_W  (LFO_W),
    .KC_W   (KC_W),
    .INC_W  (INC_W),
    .DT_W   (DtW)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .fnum     (fnum),
    .block    (block),
    .pms      (pms),
    .lfoOffset(lfoOffset),
    .keyCode  (keyCode),
    .detune   (detune),
    .incr     (incr)
  );
endmodule

// File: rtl/fm_phase_inc_chk.sv
module fm_phase_inc_chk #(
  parameter int FNUM_W  = 11,
  parameter int BLOCK_W = 3,
  parameter int PMS_W   = 3,
  parameter int INC_W   = 17
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [FNUM_W-1:0]  fnum,
  input logic [BLOCK_W-1:0] block,
  input logic [PMS_W-1:0]   pms,
  input logic [2:0]         detune,
  input logic [INC_W-1:0]   incr,
  input logic               done
);
  assert_done_follows_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    start |=> done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> !done);

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> $stable(incr));

  assert_plain_fnum_R2: assert property (@(posedge clk) disable iff (!rstN)
    (start && pms == '0 && block == BLOCK_W'(1) && detune[1:0] == 2'd0)
      |=> (incr == $past(INC_W'(fnum))));

  assert_octave_zero_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    (start && block == '0 && detune[1:0] == 2'd0) |=> (incr < INC_W'(1 << FNUM_W)));
endmodule

bind fm_phase_inc fm_phase_inc_chk #(
  .FNUM_W (FNUM_W),
  .BLOCK_W(BLOCK_W),
  .PMS_W  (PMS_W),
  .INC_W  (INC_W)
) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .fnum  (fnum),
  .block (block),
  .pms   (pms),
  .detune(detune),
  .incr  (incr),
  .done  (done)
);

// File: tb/fm_phase_inc_tb_top.sv
`timescale 1ns/1ps
module fm_phase_inc_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [10:0] fnum = '0;
  logic [2:0]  block = '0;
  logic [2:0]  pms = '0;
  logic [4:0]  lfoStep = '0;
  logic [7:0]  lfoOffset;
  logic [4:0]  keyCode = '0;
  logic [2:0]  detune = '0;
  logic [14:0] pmIndex;
  logic [16:0] incr;
  logic        done;

  int checks = 0;
  int fails = 0;
  int expInc = 0;
  int expDone = 0;
  string curTag = "R1";

  always #4 clk = ~clk;

  fm_phase_inc dut_i (
    .clk(clk), .rstN(rstN), .start(start), .fnum(fnum), .block(block),
    .pms(pms), .lfoStep(lfoStep), .lfoOffset(lfoOffset), .keyCode(keyCode),
    .detune(detune), .pmIndex(pmIndex), .incr(incr), .done(done)
  );

  // external vibrato table, a computed function of the index
  function automatic int lfoVal(int idx);
    int t;
    t = ((idx * 73) >> 3) & 255;
    if (t > 127) t = t - 256;
    return t;
  endfunction

  always_comb lfoOffset = 8'(lfoVal(int'(pmIndex)));

  function automatic int refIndex(int f, int p, int s);
    return ((f >> 4) << 8) + (p << 5) + s;
  endfunction

  function automatic int refInc(int f, int b, int p, int s, int kc, int dt);
    int base, v, sel, amt;
    if (p != 0) base = (2 * f + lfoVal(refIndex(f, p, s))) & 4095;
    else        base = f;
    if (b == 0) v = base >> 1;
    else        v = base << (b - 1);
    sel = dt & 3;
    amt = (sel == 0) ? 0 : (((kc + 1) * sel) >> 2);
    if ((dt & 4) != 0) v = v - amt;
    else               v = v + amt;
    return v & 131071;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: check outputs of the last edge, then drive new inputs
  task automatic step(int st, int f, int b, int p, int s, int kc, int dt, string tag);
    @(posedge clk);
    #3;
    check(curTag, int'(incr), expInc);
    check("R8", int'(done), expDone);
    start = st[0]; fnum = 11'(f); block = 3'(b); pms = 3'(p);
    lfoStep = 5'(s); keyCode = 5'(kc); detune = 3'(dt);
    #1;
    check("R4", int'(pmIndex), refIndex(f, p, s));
    if (st != 0) begin
      expInc = refInc(f, b, p, s, kc, dt);
      expDone = 1;
      curTag = tag;
    end else begin
      expDone = 0;
      curTag = "R8";
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check("R1", int'(incr), 0);
    check("R1", int'(done), 0);
    rstN = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, "R1");
    // R2: no vibrato, offset ignored, no doubling
    step(1, 1234, 1, 0, 17, 0, 0, "R2");
    step(1, 2047, 3, 0, 31, 9, 0, "R2");
    // R3: vibrato positive and negative wrap
    step(1, 1500, 1, 5, 3, 0, 0, "R3");
    step(1, 3, 1, 7, 29, 0, 0, "R3");
    step(1, 1, 1, 2, 11, 0, 0, "R3");
    step(1, 2047, 1, 1, 0, 0, 0, "R3");
    // R5: octave 0 and octave 7 wrap
    step(1, 1999, 0, 0, 0, 0, 0, "R5");
    step(1, 2047, 7, 0, 0, 0, 0, "R5");
    step(1, 2040, 7, 3, 6, 0, 0, "R5");
    // R6 / R7: detune add and subtract, wrap below zero
    step(1, 700, 2, 0, 0, 31, 3, "R6");
    step(1, 700, 2, 0, 0, 5, 2, "R6");
    step(1, 700, 2, 0, 0, 31, 7, "R7");
    step(1, 0, 0, 0, 0, 31, 7, "R7");
    step(1, 0, 0, 0, 0, 0, 4, "R7");
    // R8: idle cycles hold while inputs change
    step(0, 555, 4, 2, 9, 20, 1, "R8");
    step(0, 111, 6, 0, 1, 3, 6, "R8");
    step(1, 900, 4, 4, 21, 12, 5, "R8");
    step(1, 901, 5, 0, 21, 12, 1, "R8");
    for (int i = 0; i < 400; i++) begin
      step(int'($urandom_range(0, 1)), int'($urandom_range(0, 2047)),
           int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
           int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
           int'($urandom_range(0, 7)), "R7");
    end
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, "R8");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule